// File: doc/BRIEF.md
# Latched Three-Port Bus Multiplexer/Demultiplexer

This block joins two side buses, A and B, to one shared bus, AB, in both directions. Toward AB, each side bus has its own input latch, and a select line decides which of those two latches appears on AB. Away from AB, two further latches take the shared bus. One feeds only the A port and the other feeds only the B port. Because the two are loaded independently, AB values sampled at different moments can be held for the two sides. A typical use is interleaving two memory banks or splitting an address/data stream over a single shared path.

Every latch has an active-low enable. It is transparent while the enable is low and holds what it saw when the enable rose. Each port is modelled as separate input, output and output-enable vectors, so no internal tri-states are used. Every port has independent active-low enables for its upper and lower byte. A released byte drives its output-enable bit low and its output bits as zero. A build parameter chooses whether every transfer is complemented. A second build parameter replaces each level-sensitive latch with a clocked register for flows that forbid latches.

Top module: `tri_port_bus_mux`

## Requirements
- R1: An active-low asynchronous reset clears all four latches. After reset, with no latch opened, an enabled byte shows zero when INVERT=0 and all ones when INVERT=1.
- R2: Each of the four latches (A-side, B-side, AB-to-A, AB-to-B) is transparent while its active-low enable is low. A change on its data input then shows on the port it feeds.
- R3: When a latch enable rises, the latch keeps the data present at that moment. Later changes on its data input have no effect on its output port while the enable stays high.
- R4: With `sel_b` = 0 the AB outputs carry the A-side latch. With `sel_b` = 1 they carry the B-side latch.
- R5: `a_out` is fed only by the AB-to-A latch and `b_out` only by the AB-to-B latch. Loading them from AB at different times leaves two distinct held values.
- R6: Each port has a 2-bit active-low byte enable. Bit 1 covers bits 15:8 and bit 0 covers bits 7:0. Each output-enable bit equals the inverse of its byte enable bit. A released byte drives its output bits as 0.
- R7: With INVERT=1 every transfer, in both directions, is the bitwise complement of its source. With INVERT=0 data passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the register variant of the latches |
| rst_n | input | 1 | Asynchronous active-low reset of the latches |
| sel_b | input | 1 | AB source select: 0 = A-side latch, 1 = B-side latch |
| a_lat_n | input | 1 | A-side input latch enable, active low |
| b_lat_n | input | 1 | B-side input latch enable, active low |
| ab2a_lat_n | input | 1 | Enable of the latch that takes AB for the A port, active low |
| ab2b_lat_n | input | 1 | Enable of the latch that takes AB for the B port, active low |
| a_in | input | 16 | A pad input |
| a_out | output | 16 | A pad output |
| a_oe | output | 2 | A pad output enables, bit 1 upper byte |
| a_drv_n | input | 2 | A byte enables, active low, bit 1 upper byte |
| b_in | input | 16 | B pad input |
| b_out | output | 16 | B pad output |
| b_oe | output | 2 | B pad output enables, bit 1 upper byte |
| b_drv_n | input | 2 | B byte enables, active low, bit 1 upper byte |
| ab_in | input | 16 | AB pad input |
| ab_out | output | 16 | AB pad output |
| ab_oe | output | 2 | AB pad output enables, bit 1 upper byte |
| ab_drv_n | input | 2 | AB byte enables, active low, bit 1 upper byte |

## Verification
The bench closes a latch and then changes its data input. A latch that stayed open or recaptured on a level would let the new value leak onto its port. It loads the A-bound and B-bound latches from AB at different moments. If the two shared storage, or the two sides were cross-wired, both ports would show the same word. All four byte-enable combinations are run on every port, which exposes a swapped upper/lower bit or a released byte that still drives data. Two instances, one with INVERT set and one without, see the same stimulus, so a path that forgets the complement, or applies it twice, shows up on every compared word.

// File: rtl/mmx_pkg.sv
package mmx_pkg;

  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } src_sel_e;

  localparam int NBANK   = 4;
  localparam int BK_A    = 0;
  localparam int BK_B    = 1;
  localparam int BK_AB2A = 2;
  localparam int BK_AB2B = 3;

endpackage

// File: rtl/mmx_latch_bank.sv
module mmx_latch_bank #(
  parameter int W        = 16,
  parameter bit USE_FLOP = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (USE_FLOP) begin : g_flop
      logic [W-1:0] hold_q;
      logic [W-1:0] hold_nxt;
      logic         cap_en;

      assign cap_en = ~le_n;

      always_comb begin
        hold_nxt = hold_q;
        if (cap_en) hold_nxt = d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_nxt;
      end

      assign q = cap_en ? d : hold_q;
    end else begin : g_latch
      logic [W-1:0] hold_l;
      logic         unused_clk;

      assign unused_clk = clk;

      always_latch begin
        if (!rst_n)     hold_l <= '0;
        else if (!le_n) hold_l <= d;
      end

      assign q = hold_l;
    end
  endgenerate

endmodule

// File: rtl/mmx_port_drive.sv
module mmx_port_drive #(
  parameter int   DATA_W = 16,
  parameter int   LANE_W = 8,
  parameter bit   INVERT = 1'b0,
  localparam int  LANES  = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] src,
  input  logic [LANES-1:0]  en_n,
  output logic [DATA_W-1:0] out,
  output logic [LANES-1:0]  oe
);

  logic [DATA_W-1:0] pol;

  generate
    if (INVERT) begin : g_inv
      assign pol = ~src;
    end else begin : g_thru
      assign pol = src;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign oe[l] = ~en_n[l];
      assign out[l*LANE_W +: LANE_W] = oe[l] ? pol[l*LANE_W +: LANE_W]
                                             : {LANE_W{1'b0}};
    end
  endgenerate

endmodule

// File: rtl/tri_port_bus_mux.sv
module tri_port_bus_mux
  import mmx_pkg::*;
#(
  parameter int  DATA_W   = 16,
  parameter int  LANE_W   = 8,
  parameter bit  INVERT   = 1'b0,
  parameter bit  USE_FLOP = 1'b0,
  localparam int LANES    = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_b,
  input  logic              a_lat_n,
  input  logic              b_lat_n,
  input  logic              ab2a_lat_n,
  input  logic              ab2b_lat_n,
  input  logic [DATA_W-1:0] a_in,
  output logic [DATA_W-1:0] a_out,
  output logic [LANES-1:0]  a_oe,
  input  logic [LANES-1:0]  a_drv_n,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] b_out,
  output logic [LANES-1:0]  b_oe,
  input  logic [LANES-1:0]  b_drv_n,
  input  logic [DATA_W-1:0] ab_in,
  output logic [DATA_W-1:0] ab_out,
  output logic [LANES-1:0]  ab_oe,
  input  logic [LANES-1:0]  ab_drv_n
);

  logic [NBANK-1:0]             bank_le_n;
  logic [NBANK-1:0][DATA_W-1:0] bank_d;
  logic [NBANK-1:0][DATA_W-1:0] bank_q;
  logic [DATA_W-1:0]            ab_src;
  src_sel_e                     sel_e;

  // Bank index map: side inputs first, then the two AB captures
  assign bank_le_n[BK_A]    = a_lat_n;
  assign bank_le_n[BK_B]    = b_lat_n;
  assign bank_le_n[BK_AB2A] = ab2a_lat_n;
  assign bank_le_n[BK_AB2B] = ab2b_lat_n;

  assign bank_d[BK_A]    = a_in;
  assign bank_d[BK_B]    = b_in;
  assign bank_d[BK_AB2A] = ab_in;
  assign bank_d[BK_AB2B] = ab_in;

  generate
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
      mmx_latch_bank #(
        .W        (DATA_W),
        .USE_FLOP (USE_FLOP)
      ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .le_n  (bank_le_n[g]),
        .d     (bank_d[g]),
        .q     (bank_q[g])
      );
    end
  endgenerate

  assign sel_e = src_sel_e'(sel_b);

  always_comb begin
    unique case (sel_e)
      SRC_B:   ab_src = bank_q[BK_B];
      default: ab_src = bank_q[BK_A];
    endcase
  end

  mmx_port_drive #(.DATA_W(DATA_W), .LANE_W(LANE_W), .INVERT(INVERT)) u_drv_ab (
    .src  (ab_src),
    .en_n (ab_drv_n),
    .out  (ab_out),
    .oe   (ab_oe)
  );

  mmx_port_drive #(.DATA_W(DATA_W), .LANE_W(LANE_W), .INVERT(INVERT)) u_drv_a (
    .src  (bank_q[BK_AB2A]),
    .en_n (a_drv_n),
    .out  (a_out),
    .oe   (a_oe)
  );

  mmx_port_drive #(.DATA_W(DATA_W), .LANE_W(LANE_W), .INVERT(INVERT)) u_drv_b (
    .src  (bank_q[BK_AB2B]),
    .en_n (b_drv_n),
    .out  (b_out),
    .oe   (b_oe)
  );

endmodule

// File: rtl/tri_port_bus_mux_chk.sv
module tri_port_bus_mux_chk #(
  parameter int  DATA_W = 16,
  parameter int  LANE_W = 8,
  parameter bit  INVERT = 1'b0,
  localparam int LANES  = DATA_W / LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_b,
  input logic              a_lat_n,
  input logic              b_lat_n,
  input logic              ab2a_lat_n,
  input logic              ab2b_lat_n,
  input logic [DATA_W-1:0] a_in,
  input logic [DATA_W-1:0] a_out,
  input logic [LANES-1:0]  a_oe,
  input logic [LANES-1:0]  a_drv_n,
  input logic [DATA_W-1:0] b_in,
  input logic [DATA_W-1:0] b_out,
  input logic [LANES-1:0]  b_oe,
  input logic [LANES-1:0]  b_drv_n,
  input logic [DATA_W-1:0] ab_in,
  input logic [DATA_W-1:0] ab_out,
  input logic [LANES-1:0]  ab_oe,
  input logic [LANES-1:0]  ab_drv_n
);

  localparam logic [DATA_W-1:0] FLIP = INVERT ? {DATA_W{1'b1}} : {DATA_W{1'b0}};

  logic [DATA_W-1:0] a_mask, b_mask, ab_mask;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_mask
      assign a_mask[l*LANE_W +: LANE_W]  = {LANE_W{a_oe[l]}};
      assign b_mask[l*LANE_W +: LANE_W]  = {LANE_W{b_oe[l]}};
      assign ab_mask[l*LANE_W +: LANE_W] = {LANE_W{ab_oe[l]}};
    end
  endgenerate

  p_oe_follows_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_oe == ~a_drv_n) && (b_oe == ~b_drv_n) && (ab_oe == ~ab_drv_n));

  p_released_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_out & ~a_mask) == '0) && ((b_out & ~b_mask) == '0) && ((ab_out & ~ab_mask) == '0));

  p_open_ab2a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab2a_lat_n && a_drv_n == '0) |-> (a_out == (ab_in ^ FLIP)));

  p_open_ab2b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab2b_lat_n && b_drv_n == '0) |-> (b_out == (ab_in ^ FLIP)));

  p_sel_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_lat_n && !sel_b && ab_drv_n == '0) |-> (ab_out == (a_in ^ FLIP)));

  p_sel_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_lat_n && sel_b && ab_drv_n == '0) |-> (ab_out == (b_in ^ FLIP)));

  p_hold_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ab2a_lat_n && $past(ab2a_lat_n) && $stable(a_drv_n)) |-> $stable(a_out));

  p_hold_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ab2b_lat_n && $past(ab2b_lat_n) && $stable(b_drv_n)) |-> $stable(b_out));

  p_hold_ab_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_lat_n && b_lat_n && $past(a_lat_n) && $past(b_lat_n)
     && $stable(sel_b) && $stable(ab_drv_n)) |-> $stable(ab_out));

endmodule

bind tri_port_bus_mux tri_port_bus_mux_chk #(
  .DATA_W (DATA_W),
  .LANE_W (LANE_W),
  .INVERT (INVERT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_b      (sel_b),
  .a_lat_n    (a_lat_n),
  .b_lat_n    (b_lat_n),
  .ab2a_lat_n (ab2a_lat_n),
  .ab2b_lat_n (ab2b_lat_n),
  .a_in       (a_in),
  .a_out      (a_out),
  .a_oe       (a_oe),
  .a_drv_n    (a_drv_n),
  .b_in       (b_in),
  .b_out      (b_out),
  .b_oe       (b_oe),
  .b_drv_n    (b_drv_n),
  .ab_in      (ab_in),
  .ab_out     (ab_out),
  .ab_oe      (ab_oe),
  .ab_drv_n   (ab_drv_n)
);

// File: tb/tri_port_bus_mux_tb_top.sv
`timescale 1ns/1ps
module tri_port_bus_mux_tb_top;

  logic        clk;
  logic        rst_n;
  logic        sel_b;
  logic        a_lat_n, b_lat_n, ab2a_lat_n, ab2b_lat_n;
  logic [15:0] a_in, b_in, ab_in;
  logic [1:0]  a_drv_n, b_drv_n, ab_drv_n;

  logic [15:0] a_out0, b_out0, ab_out0, a_out1, b_out1, ab_out1;
  logic [1:0]  a_oe0, b_oe0, ab_oe0, a_oe1, b_oe1, ab_oe1;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  typedef struct {
    string       req;
    logic [15:0] src_a;
    logic [15:0] src_b;
    logic [15:0] src_ab;
    logic [1:0]  en_a;
    logic [1:0]  en_b;
    logic [1:0]  en_ab;
  } exp_t;

  exp_t exp_q[$];

  // reference latch contents, kept from the requirements
  logic [15:0] m_a, m_b, m_ab2a, m_ab2b;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  tri_port_bus_mux #(.INVERT(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_b(sel_b),
    .a_lat_n(a_lat_n), .b_lat_n(b_lat_n), .ab2a_lat_n(ab2a_lat_n), .ab2b_lat_n(ab2b_lat_n),
    .a_in(a_in), .a_out(a_out0), .a_oe(a_oe0), .a_drv_n(a_drv_n),
    .b_in(b_in), .b_out(b_out0), .b_oe(b_oe0), .b_drv_n(b_drv_n),
    .ab_in(ab_in), .ab_out(ab_out0), .ab_oe(ab_oe0), .ab_drv_n(ab_drv_n)
  );

  tri_port_bus_mux #(.INVERT(1'b1)) dut_inv_i (
    .clk(clk), .rst_n(rst_n), .sel_b(sel_b),
    .a_lat_n(a_lat_n), .b_lat_n(b_lat_n), .ab2a_lat_n(ab2a_lat_n), .ab2b_lat_n(ab2b_lat_n),
    .a_in(a_in), .a_out(a_out1), .a_oe(a_oe1), .a_drv_n(a_drv_n),
    .b_in(b_in), .b_out(b_out1), .b_oe(b_oe1), .b_drv_n(b_drv_n),
    .ab_in(ab_in), .ab_out(ab_out1), .ab_oe(ab_oe1), .ab_drv_n(ab_drv_n)
  );

  function automatic logic [15:0] port_exp(logic [15:0] v, logic [1:0] en_n, bit inv);
    logic [15:0] r;
    r = inv ? ~v : v;
    if (en_n[0]) r[7:0]  = 8'h00;
    if (en_n[1]) r[15:8] = 8'h00;
    return r;
  endfunction

  task automatic check(string what, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver side: update the reference latches and queue the expected item
  task automatic push_expect(string req);
    exp_t it;
    if (!a_lat_n)    m_a    = a_in;
    if (!b_lat_n)    m_b    = b_in;
    if (!ab2a_lat_n) m_ab2a = ab_in;
    if (!ab2b_lat_n) m_ab2b = ab_in;
    it.req    = req;
    it.src_a  = m_ab2a;
    it.src_b  = m_ab2b;
    it.src_ab = sel_b ? m_b : m_a;
    it.en_a   = a_drv_n;
    it.en_b   = b_drv_n;
    it.en_ab  = ab_drv_n;
    exp_q.push_back(it);
  endtask

  // monitor: compares away from the driving edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (exp_q.size() > 0) begin
        exp_t it;
        string r7;
        it = exp_q.pop_front();
        r7 = {it.req, "/R7"};
        check("a_out",  it.req, a_out0,  port_exp(it.src_a,  it.en_a,  1'b0));
        check("b_out",  it.req, b_out0,  port_exp(it.src_b,  it.en_b,  1'b0));
        check("ab_out", it.req, ab_out0, port_exp(it.src_ab, it.en_ab, 1'b0));
        check("a_out_inv",  r7, a_out1,  port_exp(it.src_a,  it.en_a,  1'b1));
        check("b_out_inv",  r7, b_out1,  port_exp(it.src_b,  it.en_b,  1'b1));
        check("ab_out_inv", r7, ab_out1, port_exp(it.src_ab, it.en_ab, 1'b1));
        check("a_oe",  {it.req, "/R6"}, {14'd0, a_oe0},  {14'd0, ~it.en_a});
        check("b_oe",  {it.req, "/R6"}, {14'd0, b_oe0},  {14'd0, ~it.en_b});
        check("ab_oe", {it.req, "/R6"}, {14'd0, ab_oe1}, {14'd0, ~it.en_ab});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sel_b = 1'b0;
    a_lat_n = 1'b1; b_lat_n = 1'b1; ab2a_lat_n = 1'b1; ab2b_lat_n = 1'b1;
    a_in = 16'h0000; b_in = 16'h0000; ab_in = 16'h0000;
    a_drv_n = 2'b11; b_drv_n = 2'b11; ab_drv_n = 2'b11;
    m_a = '0; m_b = '0; m_ab2a = '0; m_ab2b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: cleared latches, all bytes released then all driven
    @(negedge clk); a_in = 16'h7E7E; b_in = 16'h3C3C; ab_in = 16'h9999;
    push_expect("R1");
    @(negedge clk); a_drv_n = 2'b00; b_drv_n = 2'b00; ab_drv_n = 2'b00;
    push_expect("R1");

    // R2: A-side latch open, AB follows a_in
    @(negedge clk); a_lat_n = 1'b0; a_in = 16'h1234; push_expect("R2");
    @(negedge clk); a_in = 16'hABCD; push_expect("R2");
    // R3: close, then change input
    @(negedge clk); a_lat_n = 1'b1; push_expect("R3");
    @(negedge clk); a_in = 16'h5555; push_expect("R3");
    @(negedge clk); a_in = 16'hFFFF; push_expect("R3");

    // R4: B-side path and select toggling
    @(negedge clk); sel_b = 1'b1; b_lat_n = 1'b0; b_in = 16'h0F0F; push_expect("R4");
    @(negedge clk); b_lat_n = 1'b1; push_expect("R3");
    @(negedge clk); b_in = 16'hC0DE; push_expect("R3");
    @(negedge clk); sel_b = 1'b0; push_expect("R4");
    @(negedge clk); sel_b = 1'b1; push_expect("R4");

    // R5: interleave - AB taken for A, then a different AB taken for B
    @(negedge clk); ab2a_lat_n = 1'b0; ab_in = 16'h1111; push_expect("R2");
    @(negedge clk); ab_in = 16'h2468; push_expect("R2");
    @(negedge clk); ab2a_lat_n = 1'b1; push_expect("R5");
    @(negedge clk); ab_in = 16'h8421; ab2b_lat_n = 1'b0; push_expect("R5");
    @(negedge clk); ab2b_lat_n = 1'b1; push_expect("R5");
    @(negedge clk); ab_in = 16'h3333; push_expect("R3");
    @(negedge clk); ab_in = 16'hCCCC; push_expect("R5");

    // R6: every byte-enable combination on every port
    for (int e = 0; e < 4; e++) begin
      @(negedge clk);
      a_drv_n  = 2'(e);
      b_drv_n  = 2'(3 - e);
      ab_drv_n = 2'(e ^ 1);
      push_expect("R6");
    end
    @(negedge clk); a_drv_n = 2'b00; b_drv_n = 2'b00; ab_drv_n = 2'b00;
    push_expect("R6");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule